// File: doc/BRIEF.md
# Bridge Interrupt Aggregator

This block collects the interrupt lines of the devices behind a host-to-PCI bridge and turns them into one processor interrupt. That interrupt is a posted write: a programmed data word is sent to a programmed address over a request/done handshake. There are eleven line positions. Six of them carry the PCI INTA..INTF pins, one carries an external host-bus interrupt and one carries the serial port. Position 7 is a default source, position 8 has no user and position 9 is not built.

A change on a line creates an event, whether the line rises or falls. A steady level does not. Software reads the event registers to acknowledge events, and it also reads a separate register that shows the live line levels. With the two together, software can emulate level-triggered sharing. For example, it can re-trigger by hand when a line is still high after it is unmasked.

Top module: `bridge_irq_gather`

## Requirements
- R1: After reset, every register reads zero and `msg_req` is low.
- R2: Line position 9 is not implemented. The bit reads zero in the mask, live, pending and request registers, and driving `irq_in[9]` has no visible effect. Valid bits are given by mask 0x5FF.
- R3: The live register at offset 0x028 shows the synchronised level of each line, two clocks after the input. Pending and request state do not affect it.
- R4: A change in either direction on an implemented line sets its bit in the pending register (offset 0x01C), whatever the mask. Reading pending returns the bits and clears them. The read does not change the live register.
- R5: A change on a line whose mask bit (offset 0x018, bit i for line i) is 1 sets request bit i. A change on a masked line sets nothing. A line that is already high while masked raises no request or message when it is unmasked later.
- R6: Reading the request register (offset 0x00C) returns the latched requests and clears them in the same access. If a new enabled change on a line arrives in the clock where that read clears it, the change wins and the bit stays set.
- R7: When message enable (control offset 0x024, bit 0) is 1, a new request raises `msg_req`. The message carries `msg_addr` = target (offset 0x004) with bits 4:0 cleared, and `msg_data` = target bits 4:0, zero-extended.
- R8: Only one message is outstanding at a time. `msg_req`, `msg_addr` and `msg_data` hold until `msg_done`. After done, a further message goes out only if a new request arrived meanwhile and requests are still unacknowledged.
- R9: While message enable is 0, no message is raised, but request bits still latch.
- R10: The target, mask and control registers read back what was written (the mask limited to implemented bits, the control register to bit 0). Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 11 | Raw asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle `reg_rd` is high |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 32 | Message data word |
| msg_done | input | 1 | Message accepted; ends the request |

## Verification
The hardest case to reach from the ports is a new enabled change that lands in exactly the clock where a request-register read clears the same bit. An input edge takes two synchroniser stages plus the change compare before it reaches the latch. The stimulus therefore drives the edge, waits one clock, and then issues the read, so the read strobe and the latched change meet in the same cycle. A second pre-set bit with no new edge shows the clear half of that access. The resend rule is reached in a similar way: the stimulus holds `msg_done` back while further edges arrive, and in one variant acknowledges the requests before releasing done.

// File: rtl/big_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets and sender state encoding for the
// bridge interrupt aggregator. Offsets are byte addresses that software
// decodes, so they are fixed here.
package big_pkg;
    localparam logic [11:0] OFS_TARGET = 12'h004;
    localparam logic [11:0] OFS_REQ    = 12'h00C;
    localparam logic [11:0] OFS_MASK   = 12'h018;
    localparam logic [11:0] OFS_PEND   = 12'h01C;
    localparam logic [11:0] OFS_CTRL   = 12'h024;
    localparam logic [11:0] OFS_LIVE   = 12'h028;

    typedef enum logic {SND_IDLE = 1'b0, SND_BUSY = 1'b1} snd_state_e;
endpackage

// File: rtl/big_sync_edge.sv
`timescale 1ns/1ps
// Module: big_sync_edge
// Brings raw interrupt lines into the clock domain through two flops and
// flags a change whenever the synchronised level differs from the value
// registered one clock earlier.
// Assumes: lines are asynchronous and held for at least two clocks;
// unimplemented positions are forced to zero at the input.
module big_sync_edge #(
    parameter int               N         = 11,
    parameter logic [N-1:0]     IMPL_MASK = 11'h5FF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] change
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    // Two-stage synchroniser plus history register for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw & IMPL_MASK;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Live level and per-line change flags.
    assign level  = sync_q;
    assign change = sync_q ^ prev_q;
endmodule

// File: rtl/big_latch.sv
`timescale 1ns/1ps
// Module: big_latch
// Holds one pending bit and one request bit per line. Pending latches
// every change; request latches only changes on unmasked lines. Each set
// of bits clears on its own read strobe, and a same-cycle change beats
// the clear.
// Assumes: change and mask are already zero at unimplemented positions.
module big_latch #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] change,
    input  logic [N-1:0] mask,
    input  logic         clr_pend,
    input  logic         clr_req,
    output logic [N-1:0] pend,
    output logic [N-1:0] req,
    output logic         new_req
);
    logic [N-1:0] en_change;

    // Changes that are allowed to become requests.
    assign en_change = change & mask;
    assign new_req   = |en_change;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic pend_q;
        logic req_q;

        // Pending bit: set by any change, cleared by a pending read.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q <= 1'b0;
            else if (change[i])  pend_q <= 1'b1;
            else if (clr_pend)   pend_q <= 1'b0;
        end

        // Request bit: set by an unmasked change, cleared by a request read.
        always_ff @(posedge clk) begin
            if (!rst_n)            req_q <= 1'b0;
            else if (en_change[i]) req_q <= 1'b1;
            else if (clr_req)      req_q <= 1'b0;
        end

        assign pend[i] = pend_q;
        assign req[i]  = req_q;
    end

    // R6: a change meeting a clear in the same cycle leaves its bit set.
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && (en_change != '0)) |=>
        ((req & $past(en_change)) == $past(en_change)));

    // R6: a clear with no competing change empties the request register.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && (en_change == '0)) |=> (req == '0));

    // R5: a request bit only appears where an unmasked change occurred.
    a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & ~$past(req) & ~$past(en_change)) == '0));

    // R4: a pending read with no change empties the pending register.
    a_r4_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && (change == '0)) |=> (pend == '0));
endmodule

// File: rtl/big_sender.sv
`timescale 1ns/1ps
// Module: big_sender
// Issues one message write at a time. A new request arms a due flag; when
// idle, enabled and requests remain, the target is captured and the
// request is held until done. Edges seen while busy re-arm the flag.
// Assumes: msg_done is only asserted while msg_req is high.
module big_sender
    import big_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DBITS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          new_req,
    input  logic          any_req,
    input  logic [DW-1:0] target,
    input  logic          msg_done,
    output logic          msg_req,
    output logic [DW-1:0] msg_addr,
    output logic [DW-1:0] msg_data
);
    localparam logic [DW-1:0] DATA_FIELD = DW'((64'd1 << DBITS) - 64'd1);

    snd_state_e    state_q;
    logic          due_q;
    logic          issue;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Start a message when idle, armed, enabled and requests remain.
    assign issue = (state_q == SND_IDLE) && due_q && any_req && enable;

    // Due flag: armed by new requests, dropped on issue or when all acked.
    always_ff @(posedge clk) begin
        if (!rst_n)                   due_q <= 1'b0;
        else if (new_req && enable)   due_q <= 1'b1;
        else if (issue || !any_req)   due_q <= 1'b0;
    end

    // Handshake state: busy from issue until done.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   state_q <= SND_IDLE;
        else if (issue)                               state_q <= SND_BUSY;
        else if (state_q == SND_BUSY && msg_done)     state_q <= SND_IDLE;
    end

    // Capture destination and data word at issue so they hold while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (issue) begin
            addr_q <= target & ~DATA_FIELD;
            data_q <= target & DATA_FIELD;
        end
    end

    assign msg_req  = (state_q == SND_BUSY);
    assign msg_addr = addr_q;
    assign msg_data = data_q;

    // R8: an unanswered request holds with stable address and data.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_done) |=>
        (msg_req && $stable(msg_addr) && $stable(msg_data)));

    // R9: with messages disabled, an idle sender stays idle.
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_req && !enable) |=> !msg_req);
endmodule

// File: rtl/bridge_irq_gather.sv
`timescale 1ns/1ps
// Module: bridge_irq_gather (top)
// Register front end of the interrupt aggregator: target, mask and
// control storage, read mux, read-side clear strobes, and the wiring of
// the synchroniser, latch and sender.
// Assumes: reg_rd and reg_wr are single-cycle strobes; read data is taken
// combinationally in the strobe cycle and the clear applies at its edge.
module bridge_irq_gather
    import big_pkg::*;
#(
    parameter int               N         = 11,
    parameter int               DW        = 32,
    parameter int               AW        = 12,
    parameter int               DBITS     = 5,
    parameter logic [N-1:0]     IMPL_MASK = 11'h5FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          msg_req,
    output logic [DW-1:0] msg_addr,
    output logic [DW-1:0] msg_data,
    input  logic          msg_done
);
    localparam int PADW = DW - N;

    logic [DW-1:0] target_q;
    logic [N-1:0]  mask_q;
    logic          ctrl_en_q;
    logic [N-1:0]  level;
    logic [N-1:0]  change;
    logic [N-1:0]  pend;
    logic [N-1:0]  req;
    logic          new_req;
    logic          clr_pend;
    logic          clr_req;

    // Read strobes that clear latched state.
    assign clr_req  = reg_rd && (reg_addr == AW'(OFS_REQ));
    assign clr_pend = reg_rd && (reg_addr == AW'(OFS_PEND));

    // Writable registers: target, mask (implemented bits only), control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q  <= '0;
            mask_q    <= '0;
            ctrl_en_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(OFS_TARGET)) target_q  <= reg_wdata;
            if (reg_addr == AW'(OFS_MASK))   mask_q    <= reg_wdata[N-1:0] & IMPL_MASK;
            if (reg_addr == AW'(OFS_CTRL))   ctrl_en_q <= reg_wdata[0];
        end
    end

    // Read data mux; unknown offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                AW'(OFS_TARGET): reg_rdata = target_q;
                AW'(OFS_REQ):    reg_rdata = {{PADW{1'b0}}, req};
                AW'(OFS_MASK):   reg_rdata = {{PADW{1'b0}}, mask_q};
                AW'(OFS_PEND):   reg_rdata = {{PADW{1'b0}}, pend};
                AW'(OFS_CTRL):   reg_rdata = {{(DW-1){1'b0}}, ctrl_en_q};
                AW'(OFS_LIVE):   reg_rdata = {{PADW{1'b0}}, level};
                default:         reg_rdata = '0;
            endcase
        end
    end

    big_sync_edge #(.N(N), .IMPL_MASK(IMPL_MASK)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_in),
        .level  (level),
        .change (change)
    );

    big_latch #(.N(N)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .change   (change),
        .mask     (mask_q),
        .clr_pend (clr_pend),
        .clr_req  (clr_req),
        .pend     (pend),
        .req      (req),
        .new_req  (new_req)
    );

    big_sender #(.DW(DW), .DBITS(DBITS)) u_send (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctrl_en_q),
        .new_req  (new_req),
        .any_req  (|req),
        .target   (target_q),
        .msg_done (msg_done),
        .msg_req  (msg_req),
        .msg_addr (msg_addr),
        .msg_data (msg_data)
    );

    // R2: the unimplemented position never shows up in any line register.
    a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (((req | pend | level | mask_q) & ~IMPL_MASK) == '0));
endmodule

// File: tb/bridge_irq_gather_tb.sv
`timescale 1ns/1ps
// Bench for bridge_irq_gather: sweeps every line in both directions under
// several mask patterns, then walks the message handshake corner cases.
module bridge_irq_gather_tb;
    localparam logic [11:0] A_TGT  = 12'h004;
    localparam logic [11:0] A_REQ  = 12'h00C;
    localparam logic [11:0] A_MASK = 12'h018;
    localparam logic [11:0] A_PEND = 12'h01C;
    localparam logic [11:0] A_CTRL = 12'h024;
    localparam logic [11:0] A_LIVE = 12'h028;
    localparam logic [31:0] IMPL   = 32'h5FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_req;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;
    logic        msg_done = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bridge_irq_gather u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_done(msg_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        msg_done = 1'b1;
        @(negedge clk);
        msg_done = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] mexp;
        logic [31:0] bexp;
        logic [31:0] live_before;
        waitn(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and of the request output
        chk("R1 msg_req", {31'd0, msg_req}, 32'd0);
        rd(A_TGT, d);  chk("R1 target", d, 32'd0);
        rd(A_REQ, d);  chk("R1 request", d, 32'd0);
        rd(A_MASK, d); chk("R1 mask", d, 32'd0);
        rd(A_PEND, d); chk("R1 pending", d, 32'd0);
        rd(A_CTRL, d); chk("R1 control", d, 32'd0);
        rd(A_LIVE, d); chk("R1 live", d, 32'd0);

        // R10 / R2: read-back of writable registers, unknown offset
        wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, d); chk("R2 R10 mask readback", d, IMPL);
        wr(A_TGT, 32'hA5A5_1234);  rd(A_TGT, d);  chk("R10 target readback", d, 32'hA5A5_1234);
        wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, d); chk("R10 control readback", d, 32'd0);
        rd(12'h100, d); chk("R10 unknown offset", d, 32'd0);
        rd(12'h008, d); chk("R10 unknown offset 8", d, 32'd0);

        // R2: driving the unimplemented line changes nothing
        irq_in[9] = 1'b1;
        waitn(5);
        rd(A_LIVE, d); chk("R2 live bit9", d, 32'd0);
        rd(A_PEND, d); chk("R2 pend bit9", d, 32'd0);
        rd(A_REQ, d);  chk("R2 req bit9", d, 32'd0);
        irq_in[9] = 1'b0;
        waitn(5);

        // R3 R4 R5 R6 R9: sweep each line, both edges, four mask patterns
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: mexp = 32'h7FF;
                1: mexp = 32'h155;
                2: mexp = 32'h2AA;
                default: mexp = 32'h000;
            endcase
            wr(A_MASK, mexp);
            mexp = mexp & IMPL;
            for (int i = 0; i < 11; i++) begin
                bexp = (32'd1 << i) & IMPL;
                irq_in[i] = 1'b1;
                waitn(4);
                rd(A_LIVE, d); chk("R3 live after rise", d, {21'd0, irq_in} & IMPL);
                live_before = d;
                rd(A_PEND, d); chk("R4 pend after rise", d, bexp);
                rd(A_LIVE, d); chk("R4 live unchanged by pend read", d, live_before);
                rd(A_PEND, d); chk("R4 pend cleared", d, 32'd0);
                rd(A_REQ, d);  chk("R5 req after rise", d, bexp & mexp);
                rd(A_REQ, d);  chk("R6 req cleared", d, 32'd0);
                chk("R9 no message while disabled", {31'd0, msg_req}, 32'd0);
                irq_in[i] = 1'b0;
                waitn(4);
                rd(A_LIVE, d); chk("R3 live after fall", d, 32'd0);
                rd(A_PEND, d); chk("R4 pend after fall", d, bexp);
                rd(A_REQ, d);  chk("R5 req after fall", d, bexp & mexp);
            end
        end

        // R5: asserted while masked, then unmasked -> no request, no message
        wr(A_TGT, 32'h8765_4333);
        wr(A_CTRL, 32'd1);
        wr(A_MASK, 32'd0);
        irq_in[2] = 1'b1;
        waitn(6);
        rd(A_REQ, d); chk("R5 masked change no req", d, 32'd0);
        chk("R5 masked change no msg", {31'd0, msg_req}, 32'd0);
        wr(A_MASK, 32'h7FF);
        waitn(6);
        chk("R5 unmask of high line no msg", {31'd0, msg_req}, 32'd0);
        rd(A_REQ, d); chk("R5 unmask of high line no req", d, 32'd0);
        rd(A_PEND, d); chk("R4 pend set though masked", d, 32'h004);

        // R7: message content; R8: held until done, no repeat without new edge
        irq_in[3] = 1'b1;
        waitn(6);
        chk("R7 msg_req raised", {31'd0, msg_req}, 32'd1);
        chk("R7 msg_addr", msg_addr, 32'h8765_4320);
        chk("R7 msg_data", msg_data, 32'h0000_0013);
        wr(A_TGT, 32'h1111_1100);
        waitn(3);
        chk("R8 msg_req held", {31'd0, msg_req}, 32'd1);
        chk("R8 msg_addr held", msg_addr, 32'h8765_4320);
        pulse_done();
        waitn(5);
        chk("R8 no repeat without new edge", {31'd0, msg_req}, 32'd0);
        rd(A_REQ, d); chk("R6 req bit3", d, 32'h008);

        // R8: edge while busy -> second message after done
        irq_in[4] = 1'b1;
        waitn(6);
        chk("R8 first msg", {31'd0, msg_req}, 32'd1);
        chk("R7 new target addr", msg_addr, 32'h1111_1100);
        chk("R7 new target data", msg_data, 32'd0);
        irq_in[5] = 1'b1;
        waitn(6);
        chk("R8 single outstanding", {31'd0, msg_req}, 32'd1);
        pulse_done();
        waitn(5);
        chk("R8 resend after done", {31'd0, msg_req}, 32'd1);
        pulse_done();
        waitn(5);
        chk("R8 idle after second done", {31'd0, msg_req}, 32'd0);
        rd(A_REQ, d); chk("R6 req bits 4 5", d, 32'h030);

        // R8: edge while busy but requests acknowledged before done -> no resend
        irq_in[6] = 1'b1;
        waitn(6);
        chk("R8 msg for bit6", {31'd0, msg_req}, 32'd1);
        irq_in[7] = 1'b1;
        waitn(6);
        rd(A_REQ, d); chk("R6 req bits 6 7", d, 32'h0C0);
        pulse_done();
        waitn(5);
        chk("R8 no resend once acked", {31'd0, msg_req}, 32'd0);

        // R9: disabled messages, requests still latch
        wr(A_CTRL, 32'd0);
        irq_in[8] = 1'b1;
        waitn(6);
        chk("R9 no msg when disabled", {31'd0, msg_req}, 32'd0);
        rd(A_REQ, d); chk("R9 req still latched", d, 32'h100);

        // R6: new edge in the same cycle as the clearing read wins
        irq_in[0] = 1'b1;
        irq_in[1] = 1'b1;
        waitn(6);
        @(negedge clk);
        irq_in[0] = 1'b0;
        @(negedge clk);
        rd(A_REQ, d); chk("R6 read before collision", d, 32'h003);
        rd(A_REQ, d); chk("R6 colliding edge survives clear", d, 32'h001);
        rd(A_REQ, d); chk("R6 cleared afterwards", d, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule